// File: doc/BRIEF.md
# Serial Control Port Register File

This block is the configuration front end of a clock synthesis subsystem. An external controller reaches it over a four-wire serial link: an active-low select, a serial clock, a data line into the block and a data line out of it. Behind the link sit eight 5-bit register addresses. Five of them hold live settings, and the settings are driven continuously onto parallel control outputs for the clock logic. The serial lines are sampled by the block's own fast clock through synchronisers, so the serial clock is treated as data and never clocks any flop.

Every transaction is a fixed frame of sixteen serial clock periods, sampled on serial clock rising edges. The first bit is a direction flag (1 = read, 0 = write). Seven address bits follow, LSB first: bits 0..2 select the register, bits 3..5 must be zero, and bit 6 is don't-care. The last eight bits are a data byte, LSB first. A write loads the low five bits of that byte. A read turns the output driver on at the eighth falling edge and shifts the register out LSB first, padded with zeros. The output enable is low outside the read data phase, so the two data pins can share one wire.

The frame controller is a state machine with eight states. IDLE moves to HEADER when select is low. HEADER moves to TURN after the eighth rising edge. TURN moves to WDATA at once for a write, or to RDATA at the next falling edge for a read. WDATA moves to TAIL on the sixteenth rising edge, where the write commits. RDATA moves to TAIL on the falling edge after the sixteenth rising edge. TAIL moves to GAP when select rises, and the select rising in HEADER, TURN, RDATA or WDATA is an abort that also goes to GAP. GAP returns to IDLE after the minimum deselect time. If select falls in GAP, the machine goes to BLOCK, and BLOCK goes back to GAP only when select is high again.

Top module: `scp_ctrl_port`

## Requirements
- R1: After reset every register reads 00000, all parallel control outputs are 0 and `ser_dout_oe` is 0.
- R2: A complete 16-clock frame with direction bit 0, address bits 3..5 zero and register address 0..4 stores data bits 0..4 into that register. The new value appears on the control outputs once the frame ends.
- R3: In a read frame, `ser_dout_oe` rises after the eighth serial clock falling edge. Before rising edges 9 to 16, `ser_dout` presents register bits 0..4 followed by three zeros.
- R4: `ser_dout_oe` is 0 during the header bits of every frame, throughout write frames, after the sixteenth falling edge, and while idle.
- R5: Register addresses 5, 6 and 7 hold nothing: writes to them change no control output, and reads of them return 00000000.
- R6: A frame with any of address bits 3..5 set addresses no register: its write changes nothing and its read returns 00000000.
- R7: Address bit 6 (frame bit 7) has no effect on which register is written or read.
- R8: If select rises before the sixteenth rising edge, the frame is aborted and no register changes.
- R9: After select rises, it must stay high for `GAP_CYCLES` system clocks before a new frame is accepted. A frame whose select fell earlier is ignored in full, until select goes high again.
- R10: The control outputs are mapped as follows. Register 0: bit 0 = `pll1_en`, bits 4..1 = `io_mode`. Register 1: bit 0 = `pll2_en`, bits 4..1 = `pre_div`. Register 2 = `mult1_sel`. Register 3 = `mult2_sel`. Register 4: bit 0 = `out1_div8`, bit 1 = `out2_div8`, bit 2 = `out2_en`, bit 3 = `out1_en`, bit 4 = `sync_en`.
- R11: Data bits 5..7 of a write are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_cs_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial clock, idles low |
| ser_din | input | 1 | Serial data into the block |
| ser_dout | output | 1 | Serial read data |
| ser_dout_oe | output | 1 | Drive enable for `ser_dout`; 0 means high impedance |
| pll1_en | output | 1 | Register 0 bit 0 |
| io_mode | output | 4 | Register 0 bits 4..1 |
| pll2_en | output | 1 | Register 1 bit 0 |
| pre_div | output | 4 | Register 1 bits 4..1 |
| mult1_sel | output | 5 | Register 2 |
| mult2_sel | output | 5 | Register 3 |
| out1_div8 | output | 1 | Register 4 bit 0 |
| out2_div8 | output | 1 | Register 4 bit 1 |
| out2_en | output | 1 | Register 4 bit 2 |
| out1_en | output | 1 | Register 4 bit 3 |
| sync_en | output | 1 | Register 4 bit 4 |

## Verification
The bench targets the frame boundaries. It aborts a write after twelve clocks, and a design that commits early would corrupt a register. It drops select again only two system clocks after a frame, inside the deselect window, and a design without the BLOCK state would accept that frame as a real write. Reserved addresses, nonzero upper address bits, a set bit 6 and ones in data bits 5..7 each catch a decoder that aliases addresses or stores too many bits. Reads sample every output bit, and the enable at every header bit and after the frame, which exposes a turnaround that is off by one edge or a driver left on.

// File: rtl/scp_pkg.sv
package scp_pkg;
    localparam int SCP_REG_W      = 5;
    localparam int SCP_NUM_REGS   = 5;
    localparam int SCP_ADDR_W     = 3;
    localparam int SCP_HI_W       = 3;
    localparam int SCP_BYTE_W     = 8;
    localparam int SCP_HDR_BITS   = 8;
    localparam int SCP_FRAME_BITS = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_TURN,
        ST_RDATA,
        ST_WDATA,
        ST_TAIL,
        ST_GAP,
        ST_BLOCK
    } scp_state_e;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
    parameter int             WIDTH   = 3,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
                else        chain <= {chain[STAGES-2:0], d[i]};
            end
            assign q[i] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/scp_regbank.sv
module scp_regbank
    import scp_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [SCP_ADDR_W-1:0]           wr_addr,
    input  logic [SCP_REG_W-1:0]            wr_data,
    input  logic [SCP_ADDR_W-1:0]           rd_addr,
    output logic [SCP_REG_W-1:0]            rd_data,
    output logic [SCP_NUM_REGS*SCP_REG_W-1:0] cfg_flat
);
    logic [SCP_REG_W-1:0] regs [SCP_NUM_REGS];

    genvar i;
    generate
        for (i = 0; i < SCP_NUM_REGS; i++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs[i] <= '0;
                else if (wr_en && wr_addr == SCP_ADDR_W'(i))
                    regs[i] <= wr_data;
            end
            assign cfg_flat[i*SCP_REG_W +: SCP_REG_W] = regs[i];
        end
    endgenerate

    // Reserved addresses fall through to zero.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < SCP_NUM_REGS; k++)
            if (rd_addr == SCP_ADDR_W'(k)) rd_data = regs[k];
    end
endmodule

// File: rtl/scp_frame_fsm.sv
module scp_frame_fsm
    import scp_pkg::*;
#(
    parameter int GAP_CYCLES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  sclk,
    input  logic                  din,
    input  logic [SCP_REG_W-1:0]  rd_data,
    output scp_state_e            state,
    output logic                  wr_en,
    output logic [SCP_ADDR_W-1:0] wr_addr,
    output logic [SCP_REG_W-1:0]  wr_data,
    output logic [SCP_ADDR_W-1:0] rd_addr,
    output logic                  dout,
    output logic                  dout_oe
);
    localparam int CNT_W = $clog2(SCP_FRAME_BITS + 1);
    localparam int GAP_W = $clog2(GAP_CYCLES + 1);
    localparam int PAD_W = SCP_BYTE_W - SCP_REG_W;

    scp_state_e                nxt;
    logic [CNT_W-1:0]          bit_cnt;
    logic [GAP_W-1:0]          gap_cnt;
    logic [SCP_HDR_BITS-1:0]   hdr_sr;
    logic [SCP_BYTE_W-2:0]     dat_sr;
    logic [SCP_BYTE_W-1:0]     out_sr;
    logic                      sclk_prev;
    logic                      sclk_rise;
    logic                      sclk_fall;
    logic                      is_read;
    logic                      addr_ok;

    assign sclk_rise = sclk & ~sclk_prev;
    assign sclk_fall = ~sclk & sclk_prev;
    assign is_read   = hdr_sr[0];
    assign rd_addr   = hdr_sr[SCP_ADDR_W:1];
    assign addr_ok   = (hdr_sr[SCP_ADDR_W+SCP_HI_W:SCP_ADDR_W+1] == '0) &&
                       (hdr_sr[SCP_ADDR_W:1] < SCP_ADDR_W'(SCP_NUM_REGS));

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (!cs_n) nxt = ST_HEADER;
            ST_HEADER: if (cs_n) nxt = ST_GAP;
                       else if (sclk_rise && bit_cnt == CNT_W'(SCP_HDR_BITS - 1))
                           nxt = ST_TURN;
            ST_TURN:   if (cs_n) nxt = ST_GAP;
                       else if (!is_read) nxt = ST_WDATA;
                       else if (sclk_fall) nxt = ST_RDATA;
            ST_RDATA:  if (cs_n) nxt = ST_GAP;
                       else if (sclk_fall && bit_cnt == CNT_W'(SCP_FRAME_BITS))
                           nxt = ST_TAIL;
            ST_WDATA:  if (cs_n) nxt = ST_GAP;
                       else if (sclk_rise && bit_cnt == CNT_W'(SCP_FRAME_BITS - 1))
                           nxt = ST_TAIL;
            ST_TAIL:   if (cs_n) nxt = ST_GAP;
            ST_GAP:    if (!cs_n) nxt = ST_BLOCK;
                       else if (gap_cnt == GAP_W'(GAP_CYCLES - 1)) nxt = ST_IDLE;
            ST_BLOCK:  if (cs_n) nxt = ST_GAP;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Shift registers, counters and write strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            bit_cnt   <= '0;
            gap_cnt   <= '0;
            hdr_sr    <= '0;
            dat_sr    <= '0;
            out_sr    <= '0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            sclk_prev <= sclk;
            wr_en     <= 1'b0;
            gap_cnt   <= (state == ST_GAP) ? gap_cnt + 1'b1 : '0;
            case (state)
                ST_IDLE: begin
                    bit_cnt <= '0;
                    hdr_sr  <= '0;
                end
                ST_HEADER: if (sclk_rise) begin
                    hdr_sr  <= {din, hdr_sr[SCP_HDR_BITS-1:1]};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                ST_TURN: if (sclk_fall && is_read)
                    out_sr <= addr_ok ? {{PAD_W{1'b0}}, rd_data} : '0;
                ST_RDATA: begin
                    if (sclk_rise) bit_cnt <= bit_cnt + 1'b1;
                    if (sclk_fall) out_sr  <= out_sr >> 1;
                end
                ST_WDATA: if (sclk_rise && !cs_n) begin
                    dat_sr  <= {din, dat_sr[SCP_BYTE_W-2:1]};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == CNT_W'(SCP_FRAME_BITS - 1) && addr_ok) begin
                        wr_en   <= 1'b1;
                        wr_addr <= hdr_sr[SCP_ADDR_W:1];
                        wr_data <= dat_sr[SCP_REG_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        dout_oe = (state == ST_RDATA);
        dout    = dout_oe & out_sr[0];
    end
endmodule

// File: rtl/scp_ctrl_port.sv
module scp_ctrl_port
    import scp_pkg::*;
#(
    parameter int GAP_CYCLES  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_cs_n,
    input  logic       ser_clk,
    input  logic       ser_din,
    output logic       ser_dout,
    output logic       ser_dout_oe,
    output logic       pll1_en,
    output logic [3:0] io_mode,
    output logic       pll2_en,
    output logic [3:0] pre_div,
    output logic [4:0] mult1_sel,
    output logic [4:0] mult2_sel,
    output logic       out1_div8,
    output logic       out2_div8,
    output logic       out2_en,
    output logic       out1_en,
    output logic       sync_en
);
    logic [2:0]                         sync_q;
    logic                               cs_s;
    scp_state_e                         fsm_state;
    logic                               wr_en;
    logic [SCP_ADDR_W-1:0]              wr_addr;
    logic [SCP_REG_W-1:0]               wr_data;
    logic [SCP_ADDR_W-1:0]              rd_addr;
    logic [SCP_REG_W-1:0]               rd_data;
    logic [SCP_NUM_REGS*SCP_REG_W-1:0]  cfg_flat;

    // bit 0 select (idles high), bit 1 serial clock, bit 2 data
    scp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_din, ser_clk, ser_cs_n}),
        .q     (sync_q)
    );
    assign cs_s = sync_q[0];

    scp_frame_fsm #(.GAP_CYCLES(GAP_CYCLES)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_s),
        .sclk    (sync_q[1]),
        .din     (sync_q[2]),
        .rd_data (rd_data),
        .state   (fsm_state),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .dout    (ser_dout),
        .dout_oe (ser_dout_oe)
    );

    scp_regbank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .cfg_flat (cfg_flat)
    );

    assign {io_mode, pll1_en}  = cfg_flat[0*SCP_REG_W +: SCP_REG_W];
    assign {pre_div, pll2_en}  = cfg_flat[1*SCP_REG_W +: SCP_REG_W];
    assign mult1_sel           = cfg_flat[2*SCP_REG_W +: SCP_REG_W];
    assign mult2_sel           = cfg_flat[3*SCP_REG_W +: SCP_REG_W];
    assign {sync_en, out1_en, out2_en, out2_div8, out1_div8}
                               = cfg_flat[4*SCP_REG_W +: SCP_REG_W];
endmodule

// File: rtl/scp_checker.sv
module scp_checker
    import scp_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cs_s,
    input  scp_state_e                        state,
    input  logic                              wr_en,
    input  logic [SCP_ADDR_W-1:0]             wr_addr,
    input  logic                              oe,
    input  logic [SCP_NUM_REGS*SCP_REG_W-1:0] cfg
);
    // R2: register contents only move on a write strobe from the frame logic
    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg));

    // R5: the frame logic never strobes a reserved address into the bank
    assert_wr_addr_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr < SCP_ADDR_W'(SCP_NUM_REGS)));

    // R3: the driver turns on only out of the turnaround state
    assert_oe_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(state) == ST_TURN);

    // R8: a deselect shuts the driver off on the next cycle
    assert_oe_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !oe);

    // R9: nothing is written while waiting out the deselect window
    assert_no_write_in_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP || state == ST_BLOCK || state == ST_IDLE) |-> !wr_en);

    // R4: no drive outside a frame
    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_BLOCK) |-> !oe);
endmodule

bind scp_ctrl_port scp_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_s    (cs_s),
    .state   (fsm_state),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .oe      (ser_dout_oe),
    .cfg     (cfg_flat)
);

// File: tb/tb_scp_ctrl_port.sv
module tb_scp_ctrl_port;
    localparam int HALF  = 6;
    localparam int GAP   = 20;
    localparam int NREG  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_cs_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0;
    logic ser_dout, ser_dout_oe;
    logic pll1_en, pll2_en, out1_div8, out2_div8, out2_en, out1_en, sync_en;
    logic [3:0] io_mode, pre_div;
    logic [4:0] mult1_sel, mult2_sel;

    int checks = 0;
    int errors = 0;
    logic [4:0] model [NREG];

    always #5 clk = ~clk;

    scp_ctrl_port dut (
        .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk),
        .ser_din(ser_din), .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe),
        .pll1_en(pll1_en), .io_mode(io_mode), .pll2_en(pll2_en), .pre_div(pre_div),
        .mult1_sel(mult1_sel), .mult2_sel(mult2_sel), .out1_div8(out1_div8),
        .out2_div8(out2_div8), .out2_en(out2_en), .out1_en(out1_en), .sync_en(sync_en)
    );

    function automatic logic [24:0] port_cfg();
        return {sync_en, out1_en, out2_en, out2_div8, out1_div8,
                mult2_sel, mult1_sel, pre_div, pll2_en, io_mode, pll1_en};
    endfunction

    function automatic logic [24:0] model_cfg();
        return {model[4], model[3], model[2], model[1], model[0]};
    endfunction

    function automatic logic [7:0] exp_read(input logic [2:0] a, input logic [2:0] hi);
        if (hi == 3'b000 && a < 3'(NREG)) return {3'b000, model[a]};
        return 8'h00;
    endfunction

    function automatic logic [7:0] mk_hdr(input bit rd, input logic [2:0] a,
                                          input logic [2:0] hi, input bit a6);
        return {a6, hi, a, rd};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Runs one frame; stops after nbits rising edges, then deselects and waits gap.
    task automatic run_frame(input logic [7:0] hdr, input logic [7:0] data,
                             input int nbits, input int gap,
                             output logic [7:0] rd, output int oe_err);
        logic [15:0] f;
        f = {data, hdr};
        rd = '0;
        oe_err = 0;
        ser_cs_n = 1'b0;
        tick(HALF);
        for (int i = 0; i < nbits; i++) begin
            ser_din = f[i];
            tick(HALF);
            if (i >= 8 && hdr[0]) begin
                rd[i-8] = ser_dout;
                if (ser_dout_oe !== 1'b1) oe_err++;
            end else if (ser_dout_oe !== 1'b0) oe_err++;
            ser_clk = 1'b1;
            tick(HALF);
            ser_clk = 1'b0;
        end
        tick(HALF);
        if (ser_dout_oe !== 1'b0) oe_err++;
        ser_cs_n = 1'b1;
        ser_din  = 1'b0;
        tick(gap);
    endtask

    task automatic do_write(input logic [2:0] a, input logic [2:0] hi, input bit a6,
                            input logic [7:0] d, input string req);
        logic [7:0] rd;
        int oe_err;
        run_frame(mk_hdr(1'b0, a, hi, a6), d, 16, GAP, rd, oe_err);
        if (hi == 3'b000 && a < 3'(NREG)) model[a] = d[4:0];
        chk(oe_err == 0, "R4", oe_err, 0);
        chk(port_cfg() === model_cfg(), req, port_cfg(), model_cfg());
    endtask

    task automatic do_read(input logic [2:0] a, input logic [2:0] hi, input bit a6,
                           input string req);
        logic [7:0] rd;
        int oe_err;
        run_frame(mk_hdr(1'b1, a, hi, a6), 8'h00, 16, GAP, rd, oe_err);
        chk(oe_err == 0, "R3/R4 enable", oe_err, 0);
        chk(rd === exp_read(a, hi), req, rd, exp_read(a, hi));
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] rd;
        int oe_err;
        int seed;
        for (int i = 0; i < NREG; i++) model[i] = '0;
        seed = $urandom(32'h5C0F7);
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1 reset state
        chk(port_cfg() === 25'd0, "R1 cfg", port_cfg(), 0);
        chk(ser_dout_oe === 1'b0, "R1 oe", ser_dout_oe, 0);
        do_read(3'd2, 3'b000, 1'b0, "R1 read");

        // R10 field mapping, one field at a time
        do_write(3'd4, 3'b000, 1'b0, 8'h01, "R2");
        chk(out1_div8 === 1'b1 && sync_en === 1'b0, "R10 out1_div8", out1_div8, 1);
        do_write(3'd4, 3'b000, 1'b0, 8'h10, "R2");
        chk(sync_en === 1'b1 && out1_div8 === 1'b0, "R10 sync_en", sync_en, 1);
        do_write(3'd0, 3'b000, 1'b0, 8'h1E, "R2");
        chk(io_mode === 4'hF && pll1_en === 1'b0, "R10 io_mode", io_mode, 4'hF);
        do_write(3'd1, 3'b000, 1'b0, 8'h03, "R2");
        chk(pre_div === 4'h1 && pll2_en === 1'b1, "R10 pre_div", pre_div, 4'h1);
        do_write(3'd2, 3'b000, 1'b0, 8'h15, "R2");
        chk(mult1_sel === 5'h15, "R10 mult1_sel", mult1_sel, 5'h15);
        do_write(3'd3, 3'b000, 1'b0, 8'h0A, "R2");
        chk(mult2_sel === 5'h0A, "R10 mult2_sel", mult2_sel, 5'h0A);

        // R3 read back of a known pattern
        do_read(3'd2, 3'b000, 1'b0, "R3 read reg2");
        // R11 upper data bits dropped
        do_write(3'd3, 3'b000, 1'b0, 8'hE6, "R11 upper bits");
        do_read(3'd3, 3'b000, 1'b0, "R11 read back");
        // R5 reserved addresses
        do_write(3'd5, 3'b000, 1'b0, 8'h1F, "R5 write 5");
        do_write(3'd7, 3'b000, 1'b0, 8'h1F, "R5 write 7");
        do_read(3'd6, 3'b000, 1'b0, "R5 read 6");
        // R6 upper address bits set
        do_write(3'd2, 3'b001, 1'b0, 8'h07, "R6 write");
        do_write(3'd0, 3'b100, 1'b0, 8'h07, "R6 write");
        do_read(3'd2, 3'b010, 1'b0, "R6 read");
        // R7 bit 6 ignored
        do_write(3'd1, 3'b000, 1'b1, 8'h19, "R7 write");
        do_read(3'd1, 3'b000, 1'b1, "R7 read");

        // R8 aborted write after 12 clocks
        run_frame(mk_hdr(1'b0, 3'd2, 3'b000, 1'b0), 8'h1F, 12, GAP, rd, oe_err);
        chk(port_cfg() === model_cfg(), "R8 abort", port_cfg(), model_cfg());
        run_frame(mk_hdr(1'b0, 3'd0, 3'b000, 1'b0), 8'h1F, 15, GAP, rd, oe_err);
        chk(port_cfg() === model_cfg(), "R8 abort at 15", port_cfg(), model_cfg());

        // R9 frame started inside the deselect window is ignored
        run_frame(mk_hdr(1'b1, 3'd0, 3'b000, 1'b0), 8'h00, 16, 2, rd, oe_err);
        run_frame(mk_hdr(1'b0, 3'd4, 3'b000, 1'b0), 8'h0F, 16, GAP, rd, oe_err);
        chk(port_cfg() === model_cfg(), "R9 early frame", port_cfg(), model_cfg());
        do_write(3'd4, 3'b000, 1'b0, 8'h0F, "R9 frame after gap");

        // Random mix
        for (int n = 0; n < 40; n++) begin
            logic [2:0] a, hi;
            bit a6, rdir;
            logic [7:0] d;
            a    = 3'($urandom_range(0, 7));
            hi   = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(1, 7)) : 3'b000;
            a6   = 1'($urandom_range(0, 1));
            rdir = 1'($urandom_range(0, 1));
            d    = 8'($urandom_range(0, 255));
            if (rdir) do_read(a, hi, a6, "R3 random read");
            else      do_write(a, hi, a6, d, "R2 random write");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule